// File: doc/BRIEF.md
# Rate-Selectable Parallel Sample Bus Interface

This block carries a stream of 32-bit sample words across a parallel lane bus. The transmit half spreads each accepted word over 16 or 32 lanes. The rate code sets the lane count and the bus clock rate together. Each 16-lane group has its own strobe clock. The transmit half drives a validity line with the lanes. It also turns the rising edge of a station one-second tick into a one-bus-cycle marker.

The receive half rebuilds the words. It samples the lower lane group only on rising edges of the primary clock and the upper group only on rising edges of the secondary clock, so the two groups can arrive with a skew between them. It tags the word that lines up with the one-second marker, so that downstream logic can find the epoch.

Bus clocks are derived from the system clock. The fastest mode has a half period of `BASE_HALF` system cycles. In the six modes the ratios between bus clock rates are 1:2:4:8:8:16, slowest first, and the top two modes use all 32 lanes.

Top module: `psb_link`

## Requirements
- R1: After reset the transmit clocks, `tx_valid`, `tx_pps` and `out_vld` are low and `in_ready` is high.
- R2: Rate codes 0 to 5 select bus clock half periods of `BASE_HALF` shifted left by 4, 3, 2, 1, 1 and 0 system cycles. Codes 0 to 3 use 16 lanes and codes 4 and 5 use 32 lanes. Codes 6 and 7 are ignored, and the previous rate stays in force.
- R3: In a 16-lane mode each word takes two valid bus cycles, bits 15:0 first and then bits 31:16, both on lanes 15:0. In these modes lanes 31:16 stay zero and `tx_clk_sec` stays low.
- R4: In a 32-lane mode each word takes one valid bus cycle. Bits 31:16 go on lanes 31:16, and `tx_clk_sec` follows `tx_clk_pri`.
- R5: `tx_lanes` and `tx_valid` change only when `tx_clk_pri` falls, which is half a bus period before the capturing rise.
- R6: The receiver takes lanes 15:0 and `rx_valid` only on rises of `rx_clk_pri`, and lanes 31:16 only on rises of `rx_clk_sec`. The secondary clock and lanes may lag the primary by less than half a bus period. Words come out in the order they were accepted, in every mode.
- R7: A new rate code takes effect only at a falling edge that ends a bus cycle with no data and no pending half word. While words keep streaming the request waits, and the change cycle carries `tx_valid` low.
- R8: Each rising edge of `pps_in` makes `tx_pps` high for exactly one bus cycle, starting at the next falling edge of the primary clock, whatever the width of the input pulse.
- R9: `out_epoch` marks the word completed with the beat captured together with a rise of `rx_pps`. If that beat is idle, the mark goes to the next word instead. Every other word is unmarked.
- R10: `out_vld` is a one-cycle pulse per rebuilt word, and `out_epoch` is high only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Requested rate code |
| in_word | input | 32 | Sample word to send |
| in_valid | input | 1 | `in_word` is offered |
| in_ready | output | 1 | One-word input slot is free |
| pps_in | input | 1 | Station one-second tick |
| tx_clk_pri | output | 1 | Strobe for lanes 15:0 |
| tx_clk_sec | output | 1 | Strobe for lanes 31:16 |
| tx_lanes | output | 32 | Transmit lanes |
| tx_valid | output | 1 | Transmit lanes carry data |
| tx_pps | output | 1 | One-bus-cycle tick marker |
| rx_clk_pri | input | 1 | Received strobe for lanes 15:0 |
| rx_clk_sec | input | 1 | Received strobe for lanes 31:16 |
| rx_lanes | input | 32 | Received lanes |
| rx_valid | input | 1 | Received validity line |
| rx_pps | input | 1 | Received tick marker |
| out_word | output | 32 | Rebuilt word |
| out_vld | output | 1 | `out_word` is new this cycle |
| out_epoch | output | 1 | Rebuilt word is the epoch word |

## Verification
The epoch capture and the completion of a word can fall in the same receiver cycle. In a 16-lane mode this happens when the tick marker rides on the second half of a word. The bench provokes it by raising `pps_in` just after it sees a first half launched on the lanes. It reads that word's index from lanes 14:0 and requires the mark on exactly that word. In a 32-lane mode with a skewed secondary group, the same stimulus must instead mark the following word, after the skewed upper half of the current word has completed it.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef logic [2:0] rate_t;

  localparam rate_t RATE_MAX = 3'd5;

  function automatic logic rate_legal(rate_t r);
    return r <= RATE_MAX;
  endfunction

  function automatic logic rate_wide(rate_t r);
    return (r == 3'd4) || (r == 3'd5);
  endfunction

  // left shift applied to the base half period
  function automatic logic [2:0] rate_shift(rate_t r);
    case (r)
      3'd0:    return 3'd4;
      3'd1:    return 3'd3;
      3'd2:    return 3'd2;
      3'd3:    return 3'd1;
      3'd4:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/psb_rate_div.sv
module psb_rate_div #(
  parameter int BASE_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] shift,
  output logic       tick,
  output logic       lvl
);
  localparam int CW = $clog2(BASE_HALF * 16) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;

  assign half = CW'(BASE_HALF) << shift;
  assign tick = (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      lvl <= ~lvl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt < half);
endmodule

// File: rtl/psb_tx.sv
module psb_tx
  import psb_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int BASE_HALF = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  rate_t              rate_sel,
  input  logic [2*LANES-1:0] in_word,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               pps_in,
  output logic               clk_pri,
  output logic               clk_sec,
  output logic [2*LANES-1:0] lanes,
  output logic               lane_valid,
  output logic               lane_pps,
  output rate_t              act_mode
);
  localparam int WW = 2 * LANES;

  logic             tick, lvl, fall, pps_q, pps_rise, pps_pend;
  logic             hold_full, hi_pend, change_ok;
  logic [WW-1:0]    hold_word;
  logic [LANES-1:0] hi_half;

  psb_rate_div #(.BASE_HALF(BASE_HALF)) div_i (
    .clk   (clk),
    .rst   (rst),
    .shift (rate_shift(act_mode)),
    .tick  (tick),
    .lvl   (lvl)
  );

  assign clk_pri   = lvl;
  assign in_ready  = ~hold_full;
  assign fall      = tick & lvl;
  assign pps_rise  = pps_in & ~pps_q;
  assign change_ok = ~lane_valid & ~hi_pend & rate_legal(rate_sel) & (rate_sel != act_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full  <= 1'b0;
      hold_word  <= '0;
      hi_pend    <= 1'b0;
      hi_half    <= '0;
      lanes      <= '0;
      lane_valid <= 1'b0;
      lane_pps   <= 1'b0;
      pps_q      <= 1'b0;
      pps_pend   <= 1'b0;
      act_mode   <= '0;
      clk_sec    <= 1'b0;
    end else begin
      pps_q   <= pps_in;
      clk_sec <= rate_wide(act_mode) & (tick ? ~lvl : lvl);
      if (in_valid && !hold_full) begin
        hold_word <= in_word;
        hold_full <= 1'b1;
      end
      if (fall) begin
        lane_pps <= pps_pend;
        pps_pend <= pps_rise;
        if (hi_pend) begin
          lanes[LANES-1:0] <= hi_half;
          lane_valid       <= 1'b1;
          hi_pend          <= 1'b0;
        end else if (change_ok) begin
          act_mode   <= rate_sel;
          lanes      <= '0;
          lane_valid <= 1'b0;
        end else if (hold_full) begin
          hold_full  <= 1'b0;
          lane_valid <= 1'b1;
          if (rate_wide(act_mode)) begin
            lanes <= hold_word;
          end else begin
            lanes   <= {{LANES{1'b0}}, hold_word[LANES-1:0]};
            hi_half <= hold_word[WW-1:LANES];
            hi_pend <= 1'b1;
          end
        end else begin
          lane_valid <= 1'b0;
        end
      end else if (pps_rise) begin
        pps_pend <= 1'b1;
      end
    end
  end

  // R5
  launch_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lanes) || !$stable(lane_valid)) |-> $past(fall));
  // R7
  mode_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_mode) |-> (!$past(lane_valid) && !$past(hi_pend) && !lane_valid));
  // R3
  narrow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rate_wide(act_mode) |-> (lanes[WW-1:LANES] == '0 && !clk_sec));
endmodule

// File: rtl/psb_rx.sv
module psb_rx
  import psb_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  rate_t              mode,
  input  logic               clk_pri,
  input  logic               clk_sec,
  input  logic [2*LANES-1:0] lanes,
  input  logic               lane_valid,
  input  logic               lane_pps,
  output logic [2*LANES-1:0] word_o,
  output logic               word_vld,
  output logic               word_epoch
);
  localparam int WW = 2 * LANES;

  logic             a_q, b_q, pps_q, ep_pend, lo_pend, half_in;
  logic             a_rise, b_rise, ep_now, take_lo, wide;
  logic [LANES-1:0] lo_reg;
  rate_t            mode_q;

  always_comb begin
    a_rise  = clk_pri & ~a_q;
    b_rise  = clk_sec & ~b_q;
    ep_now  = a_rise & lane_pps & ~pps_q;
    take_lo = a_rise & lane_valid;
    wide    = rate_wide(mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q        <= 1'b0;
      b_q        <= 1'b0;
      pps_q      <= 1'b0;
      ep_pend    <= 1'b0;
      lo_pend    <= 1'b0;
      half_in    <= 1'b0;
      lo_reg     <= '0;
      mode_q     <= '0;
      word_o     <= '0;
      word_vld   <= 1'b0;
      word_epoch <= 1'b0;
    end else begin
      a_q        <= clk_pri;
      b_q        <= clk_sec;
      mode_q     <= mode;
      word_vld   <= 1'b0;
      word_epoch <= 1'b0;
      if (a_rise) pps_q <= lane_pps;
      if (ep_now) ep_pend <= 1'b1;
      if (wide) begin
        if (take_lo) begin
          lo_reg  <= lanes[LANES-1:0];
          lo_pend <= 1'b1;
        end
        if (b_rise && (lo_pend || take_lo)) begin
          word_o     <= {lanes[WW-1:LANES], lo_pend ? lo_reg : lanes[LANES-1:0]};
          word_vld   <= 1'b1;
          word_epoch <= ep_pend | ep_now;
          ep_pend    <= 1'b0;
          lo_pend    <= 1'b0;
        end
      end else if (take_lo) begin
        if (!half_in) begin
          lo_reg  <= lanes[LANES-1:0];
          half_in <= 1'b1;
        end else begin
          word_o     <= {lanes[LANES-1:0], lo_reg};
          word_vld   <= 1'b1;
          word_epoch <= ep_pend | ep_now;
          ep_pend    <= 1'b0;
          half_in    <= 1'b0;
        end
      end
      if (mode != mode_q) begin
        lo_pend <= 1'b0;
        half_in <= 1'b0;
      end
    end
  end

  // R10
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst) word_vld |=> !word_vld);
  // R10
  epoch_with_word_chk: assert property (@(posedge clk) disable iff (rst) word_epoch |-> word_vld);
endmodule

// File: rtl/psb_link.sv
module psb_link #(
  parameter int LANES     = 16,
  parameter int BASE_HALF = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         rate_sel,
  input  logic [2*LANES-1:0] in_word,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               pps_in,
  output logic               tx_clk_pri,
  output logic               tx_clk_sec,
  output logic [2*LANES-1:0] tx_lanes,
  output logic               tx_valid,
  output logic               tx_pps,
  input  logic               rx_clk_pri,
  input  logic               rx_clk_sec,
  input  logic [2*LANES-1:0] rx_lanes,
  input  logic               rx_valid,
  input  logic               rx_pps,
  output logic [2*LANES-1:0] out_word,
  output logic               out_vld,
  output logic               out_epoch
);
  logic [2:0] act_mode;

  psb_tx #(.LANES(LANES), .BASE_HALF(BASE_HALF)) tx_i (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .in_word    (in_word),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .pps_in     (pps_in),
    .clk_pri    (tx_clk_pri),
    .clk_sec    (tx_clk_sec),
    .lanes      (tx_lanes),
    .lane_valid (tx_valid),
    .lane_pps   (tx_pps),
    .act_mode   (act_mode)
  );

  psb_rx #(.LANES(LANES)) rx_i (
    .clk        (clk),
    .rst        (rst),
    .mode       (act_mode),
    .clk_pri    (rx_clk_pri),
    .clk_sec    (rx_clk_sec),
    .lanes      (rx_lanes),
    .lane_valid (rx_valid),
    .lane_pps   (rx_pps),
    .word_o     (out_word),
    .word_vld   (out_vld),
    .word_epoch (out_epoch)
  );
endmodule

// File: tb/psb_link_tb.sv
`timescale 1ns/1ps
module psb_link_tb_top;
  localparam int BH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rate_sel = 3'd0;
  logic [31:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        pps_in = 1'b0;
  logic        in_ready, tx_clk_pri, tx_clk_sec, tx_valid, tx_pps;
  logic [31:0] tx_lanes, out_word;
  logic        out_vld, out_epoch;
  logic        rx_clk_sec;
  logic [31:0] rx_lanes;

  int checks = 0, errors = 0;
  int sent = 0, got = 0, mark_idx = -1, epochs = 0, marks = 0;
  int lag = 0, beats = 0, nar_bad = 0, edge_bad = 0;
  bit lane_on = 1'b0;
  logic [3:0]  clkd;
  logic [15:0] hid [4];

  always #10 clk = ~clk;

  psb_link #(.LANES(16), .BASE_HALF(BH)) dut_i (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .pps_in(pps_in), .tx_clk_pri(tx_clk_pri), .tx_clk_sec(tx_clk_sec),
    .tx_lanes(tx_lanes), .tx_valid(tx_valid), .tx_pps(tx_pps), .rx_clk_pri(tx_clk_pri),
    .rx_clk_sec(rx_clk_sec), .rx_lanes(rx_lanes), .rx_valid(tx_valid), .rx_pps(tx_pps),
    .out_word(out_word), .out_vld(out_vld), .out_epoch(out_epoch));

  // skew line for the secondary group
  always_ff @(posedge clk) begin
    clkd <= {clkd[2:0], tx_clk_sec};
    hid[0] <= tx_lanes[31:16];
    for (int k = 1; k < 4; k++) hid[k] <= hid[k-1];
  end
  always_comb begin
    rx_clk_sec = (lag == 0) ? tx_clk_sec : clkd[lag-1];
    rx_lanes   = {(lag == 0) ? tx_lanes[31:16] : hid[lag-1], tx_lanes[15:0]};
  end

  function automatic logic [31:0] wval(int i);
    return {1'b1, ~i[14:0], 1'b0, i[14:0]};
  endfunction

  function automatic int exp_period(int m);
    int s;
    case (m) 0: s = 4; 1: s = 3; 2: s = 2; 3: s = 1; 4: s = 1; default: s = 0; endcase
    return 2 * (BH << s);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // port monitor, sampled away from the active edge
  logic       pa_mon = 1'b0, pv_mon = 1'b0;
  logic [31:0] pl_mon = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (out_vld) begin
        chk(out_word == wval(got), "R6", "word order", out_word, wval(got));
        chk(out_epoch == (got == mark_idx), "R9", "epoch flag", out_epoch, (got == mark_idx));
        if (out_epoch) epochs++;
        got++;
      end
      if (tx_clk_pri && !pa_mon && tx_valid) beats++;
      if (lane_on && (tx_clk_sec || tx_lanes[31:16] != 16'h0)) nar_bad++;
      if ((tx_lanes != pl_mon || tx_valid != pv_mon) && !(pa_mon && !tx_clk_pri)) edge_bad++;
    end
    pa_mon = tx_clk_pri; pv_mon = tx_valid; pl_mon = tx_lanes;
  end

  task automatic send_words(int n);
    for (int i = 0; i < n; i++) begin
      bit r;
      in_word = wval(sent); in_valid = 1'b1;
      forever begin r = in_ready; @(negedge clk); if (r) break; end
      in_valid = 1'b0; sent++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && got != sent; i++) @(negedge clk);
    chk(got == sent, "R6", "all words rebuilt", got, sent);
  endtask

  task automatic measure(output int p);
    logic pa = tx_clk_pri;
    forever begin @(negedge clk); if (tx_clk_pri && !pa) break; pa = tx_clk_pri; end
    p = 0; pa = tx_clk_pri;
    forever begin @(negedge clk); p++; if (tx_clk_pri && !pa) break; pa = tx_clk_pri; end
  endtask

  // raise the tick just after a first half (or a whole word) is launched
  task automatic inject(bit wide);
    logic pa = tx_clk_pri;
    wait (sent >= 3);
    forever begin
      @(negedge clk);
      if (pa && !tx_clk_pri && tx_valid && !tx_lanes[15]) break;
      pa = tx_clk_pri;
    end
    mark_idx = int'(tx_lanes[14:0]) + (wide ? 1 : 0);
    marks++;
    pps_in = 1'b1; repeat (20) @(negedge clk); pps_in = 1'b0;
  endtask

  task automatic run_mode(int m, int lg, bit do_pps);
    int p;
    bit w = (m >= 4);
    rate_sel = 3'(m); lag = lg;
    repeat (300) @(negedge clk);
    measure(p);
    chk(p == exp_period(m), "R2", "bus period", p, exp_period(m));
    beats = 0; nar_bad = 0; lane_on = !w;
    fork
      send_words(12);
      if (do_pps) inject(w);
    join
    drain();
    lane_on = 1'b0;
    if (w) chk(beats == 12, "R4", "one beat per word", beats, 12);
    else begin
      chk(beats == 24, "R3", "two beats per word", beats, 24);
      chk(nar_bad == 0, "R3", "upper lanes quiet", nar_bad, 0);
    end
  endtask

  initial begin
    int p;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!tx_valid && !tx_pps && !tx_clk_pri && !tx_clk_sec, "R1", "bus idle", tx_valid, 0);
    chk(!out_vld && in_ready, "R1", "ready and no output", {out_vld, in_ready}, 1);

    run_mode(0, 0, 1'b1);   // R9 epoch lands with word completion
    run_mode(1, 0, 1'b0);
    run_mode(2, 0, 1'b0);
    run_mode(3, 0, 1'b0);
    run_mode(4, 3, 1'b0);   // R6 skewed secondary group
    run_mode(5, 1, 1'b1);

    // R2 reserved code is ignored
    rate_sel = 3'd7;
    repeat (300) @(negedge clk);
    measure(p);
    chk(p == exp_period(5), "R2", "reserved code ignored", p, exp_period(5));
    send_words(4); drain();

    // R7 a change requested mid-stream waits for idle
    run_mode(2, 0, 1'b0);
    fork
      send_words(16);
      begin
        wait (sent >= 4);
        rate_sel = 3'd3;
        measure(p);
        chk(p == exp_period(2), "R7", "rate held while streaming", p, exp_period(2));
      end
    join
    drain();
    repeat (300) @(negedge clk);
    measure(p);
    chk(p == exp_period(3), "R7", "rate taken after idle", p, exp_period(3));

    // R8 long tick pulse on an idle bus marks only the next word
    mark_idx = sent; marks++;
    pps_in = 1'b1; repeat (500) @(negedge clk); pps_in = 1'b0;
    repeat (20) @(negedge clk);
    send_words(4); drain();
    chk(epochs == marks, "R8", "one mark per tick", epochs, marks);
    chk(edge_bad == 0, "R5", "lanes change on falling edge", edge_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule